// File: doc/BRIEF.md
# Sleep Power-Down Sequencer

This block controls the low-power state of a synchronous memory. A sleep request arrives from outside the clock domain, is active high, and reads as inactive when nothing drives it. The request passes through a two-flop synchroniser. Once it has been seen high for long enough, the sequencer enters sleep. While asleep it blocks every command at the memory's input and drives the output-disable signal. The address register it manages keeps its value through the whole interval.

After the request falls, the sequencer does not return to normal operation at once. It runs a recovery interval of a set number of cycles. During that interval reads and deselects pass through to the memory. A write is blocked, and a one-cycle illegal-command flag reports it. A request that drops before entry completes cancels the entry, and no sleep takes place.

Commands are given by a select bit and a write bit. Select low is a deselect. Select high with write low is a read. Select high with write high is a write. Accepted commands leave the block on a registered forwarding port one clock edge later.

Top module: `sleep_pd_seq`

## Requirements
- R1: While reset is held low, all outputs read zero at the next rising edge, including fwd_addr.
- R2: The request is sampled by two flops in series. sleep_active rises on the second rising edge after the synchroniser output first reads high. Counted from the first edge that samples the raw request high, that is the fourth edge.
- R3: If the synchronised request falls before entry completes, entry is cancelled. A raw request that is high at only one sampling edge never raises sleep_active.
- R4: While sleep_active is high, in_block and out_hiz are high. A command presented in that state gives fwd_valid=0, fwd_write=0 and illegal_cmd=0 at the next edge.
- R5: sleep_active stays high for as long as the synchronised request stays high.
- R6: sleep_active falls on the third edge after the first edge that samples the raw request low. recov_busy rises on that same edge and stays high for exactly RECOVERY_CYCLES cycles (default 8).
- R7: A command presented while recov_busy is high is handled as follows at the next edge. A read gives fwd_valid=1 and fwd_write=0. A deselect gives fwd_valid=0. A write is blocked (fwd_valid=0) and sets illegal_cmd=1 for that one cycle.
- R8: fwd_addr loads cmd_addr only when a command is accepted. It keeps its value through sleep, through blocked writes and through deselects.
- R9: sleep_active and recov_busy are never high at the same time.
- R10: Outside sleep and recovery, including during the entry count, a command is forwarded at the next edge with fwd_valid=cmd_sel and fwd_write=cmd_sel&cmd_we, and illegal_cmd stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| cmd_sel | input | 1 | Command select (0 = deselect) |
| cmd_we | input | 1 | Write when selected (0 = read) |
| cmd_addr | input | ADDR_W | Command address |
| sleep_active | output | 1 | High while asleep |
| in_block | output | 1 | High while memory inputs are gated off |
| out_hiz | output | 1 | High while memory outputs must be high impedance |
| recov_busy | output | 1 | High during the post-sleep recovery interval |
| illegal_cmd | output | 1 | One-cycle pulse for a write blocked during recovery |
| fwd_valid | output | 1 | Registered: an accepted command is present |
| fwd_write | output | 1 | Registered: the accepted command is a write |
| fwd_addr | output | ADDR_W | Address of the last accepted command |

## Verification
The assertions take cmd_sel and cmd_we as known, two-valued levels that hold steady around each rising edge. sleep_req needs no such guarantee, because it only reaches the logic through the synchroniser. The entry check assumes the synchroniser output stays high across both edges before sleep starts. That is what a real request does, since a short pulse is cancelled instead. The bench changes every input at the falling edge only, so each value is stable a half period before the edge that samples it. It holds the request at one level for whole runs of cycles, which makes the count of edges to each expected transition exact.

// File: rtl/sleep_seq_pkg.sv
// Package: shared constants and state type of the sleep power-down sequencer.
// Assumes: it is compiled before every module that imports it.
package sleep_seq_pkg;

    // Cycles from the first synchronised-high sample to sleep (fixed by design)
    localparam int ENTRY_CYCLES = 2;

    // Power state of the sequencer
    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_ENTER = 2'd1,
        PS_SLEEP = 2'd2,
        PS_RECOV = 2'd3
    } pwr_state_t;

endpackage

// File: rtl/sleep_req_sync.sv
// Module: shift-register synchroniser for the asynchronous sleep request.
// Assumes: STAGES >= 2, and the input may change at any time relative to clk.
module sleep_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    // First stage samples the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= 1'b0;
        else        stg[0] <= d;
    end

    // Each later stage samples the one before it
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= 1'b0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

    // R2: a rising output was already present at the input two edges earlier
    p_sync_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(d, 2));

endmodule

// File: rtl/sleep_pwr_fsm.sv
// Module: power-state sequencer (run, entry count, sleep, recovery count).
// Assumes: req_sync is already synchronised to clk; RECOVERY_CYCLES >= 1.
module sleep_pwr_fsm
    import sleep_seq_pkg::*;
#(
    parameter int RECOVERY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    output logic asleep,
    output logic recov_busy
);
    localparam int EW = (ENTRY_CYCLES > 2) ? $clog2(ENTRY_CYCLES - 1) : 1;
    localparam int RW = (RECOVERY_CYCLES > 1) ? $clog2(RECOVERY_CYCLES) : 1;
    localparam logic [EW-1:0] ENTRY_LAST = EW'(ENTRY_CYCLES - 2);
    localparam logic [RW-1:0] RECOV_LAST = RW'(RECOVERY_CYCLES - 1);

    pwr_state_t    st;
    logic [EW-1:0] ecnt;
    logic [RW-1:0] rcnt;

    // State transitions plus the entry and recovery counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= PS_RUN;
            ecnt <= '0;
            rcnt <= '0;
        end else begin
            case (st)
                PS_RUN: begin
                    if (req_sync) begin
                        st   <= PS_ENTER;
                        ecnt <= '0;
                    end
                end
                PS_ENTER: begin
                    if (!req_sync)               st   <= PS_RUN;
                    else if (ecnt == ENTRY_LAST) st   <= PS_SLEEP;
                    else                         ecnt <= ecnt + 1'b1;
                end
                PS_SLEEP: begin
                    if (!req_sync) begin
                        st   <= PS_RECOV;
                        rcnt <= '0;
                    end
                end
                PS_RECOV: begin
                    if (rcnt == RECOV_LAST) st   <= PS_RUN;
                    else                    rcnt <= rcnt + 1'b1;
                end
                default: st <= PS_RUN;
            endcase
        end
    end

    // Status flags decoded from the state register
    always_comb begin
        asleep     = (st == PS_SLEEP);
        recov_busy = (st == PS_RECOV);
    end

    // R9: sleep and recovery flags are mutually exclusive
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(asleep && recov_busy));

    // R5: a held request keeps the block asleep
    p_hold_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && req_sync) |=> asleep);

    // R2: sleep begins only after two consecutive synchronised-high samples
    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> ($past(req_sync) && $past(req_sync, 2)));

    // R6: leaving sleep always lands in recovery
    p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> recov_busy);

endmodule

// File: rtl/sleep_cmd_filter.sv
// Module: registered command gate; drops everything while asleep and
//         blocks writes (flagging them) during recovery.
// Assumes: asleep and recov_busy are never high together.
module sleep_cmd_filter #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              asleep,
    input  logic              recov_busy,
    input  logic              cmd_sel,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              fwd_valid,
    output logic              fwd_write,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              illegal_cmd
);
    logic accept;

    // Acceptance: selected, awake, and not a write during recovery
    always_comb begin
        accept = cmd_sel && !asleep && !(recov_busy && cmd_we);
    end

    // Forwarding registers; the address register is retained unless loaded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid   <= 1'b0;
            fwd_write   <= 1'b0;
            fwd_addr    <= '0;
            illegal_cmd <= 1'b0;
        end else begin
            fwd_valid   <= accept;
            fwd_write   <= accept && cmd_we;
            illegal_cmd <= recov_busy && cmd_sel && cmd_we;
            if (accept) fwd_addr <= cmd_addr;
        end
    end

    // R7: no write leaves the block for a command seen during recovery
    p_no_wr_recov_r7: assert property (@(posedge clk) disable iff (!rst_n)
        recov_busy |=> !fwd_write);

    // R4: commands seen while asleep produce nothing
    p_ignore_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> (!fwd_valid && !illegal_cmd));

    // R8: the address register is retained across a sleeping cycle
    p_addr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> $stable(fwd_addr));

    // R7: a flagged command is never also forwarded
    p_illegal_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cmd |-> !fwd_valid);

endmodule

// File: rtl/sleep_pd_seq.sv
// Module: top of the sleep power-down sequencer. Synchronises the request,
//         runs the power state machine, and filters commands.
// Assumes: cmd_* are synchronous to clk; sleep_req may be asynchronous.
module sleep_pd_seq #(
    parameter int ADDR_W          = 18,
    parameter int SYNC_STAGES     = 2,
    parameter int RECOVERY_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              cmd_sel,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              sleep_active,
    output logic              in_block,
    output logic              out_hiz,
    output logic              recov_busy,
    output logic              illegal_cmd,
    output logic              fwd_valid,
    output logic              fwd_write,
    output logic [ADDR_W-1:0] fwd_addr
);
    logic req_sync;
    logic asleep;
    logic busy;

    sleep_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sleep_req),
        .q     (req_sync)
    );

    sleep_pwr_fsm #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_sync   (req_sync),
        .asleep     (asleep),
        .recov_busy (busy)
    );

    sleep_cmd_filter #(.ADDR_W(ADDR_W)) u_filt (
        .clk         (clk),
        .rst_n       (rst_n),
        .asleep      (asleep),
        .recov_busy  (busy),
        .cmd_sel     (cmd_sel),
        .cmd_we      (cmd_we),
        .cmd_addr    (cmd_addr),
        .fwd_valid   (fwd_valid),
        .fwd_write   (fwd_write),
        .fwd_addr    (fwd_addr),
        .illegal_cmd (illegal_cmd)
    );

    // Output gating follows the sleep state directly
    always_comb begin
        sleep_active = asleep;
        in_block     = asleep;
        out_hiz      = asleep;
        recov_busy   = busy;
    end

    // R4: gating signals track the sleep flag
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active |-> (in_block && out_hiz));

endmodule

// File: tb/sim_sleep_pd_seq.sv
// Bench: scoreboard. The driver pushes the expected post-edge outputs into a
// queue; the monitor pops and compares them just after each rising edge.
module sim_sleep_pd_seq;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic          cmd_sel = 1'b0;
    logic          cmd_we = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          sleep_active, in_block, out_hiz, recov_busy;
    logic          illegal_cmd, fwd_valid, fwd_write;
    logic [AW-1:0] fwd_addr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [14:0] exp_q[$];
    string       tag_q[$];

    bit            prev_s = 1'b0;
    bit            prev_b = 1'b0;
    logic [AW-1:0] exp_addr = '0;

    sleep_pd_seq #(.ADDR_W(AW), .SYNC_STAGES(2), .RECOVERY_CYCLES(8)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .cmd_sel(cmd_sel), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .sleep_active(sleep_active), .in_block(in_block), .out_hiz(out_hiz),
        .recov_busy(recov_busy), .illegal_cmd(illegal_cmd),
        .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_addr(fwd_addr)
    );

    always #5 clk = ~clk;

    function automatic logic [14:0] observed();
        return {sleep_active, recov_busy, in_block, out_hiz,
                fwd_valid, fwd_write, illegal_cmd, fwd_addr};
    endfunction

    // Driver: one cycle of stimulus plus the expected outputs after the edge
    task automatic step(input bit req, input bit sel, input bit we,
                        input logic [AW-1:0] a, input bit es, input bit eb,
                        input string tag);
        bit ev, ew, ei;
        @(negedge clk);
        sleep_req = req;
        cmd_sel   = sel;
        cmd_we    = we;
        cmd_addr  = a;
        ev = sel && !prev_s && !(prev_b && we);
        ew = ev && we;
        ei = prev_b && sel && we;
        if (ev) exp_addr = a;
        exp_q.push_back({es, eb, es, es, ev, ew, ei, exp_addr});
        tag_q.push_back(tag);
        prev_s = es;
        prev_b = eb;
    endtask

    // Monitor: compare just after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [14:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (observed() !== e) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", t, observed(), e);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog all-reqs actual=%0d cycles expected<20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state with inputs active
        sleep_req = 1'b1; cmd_sel = 1'b1; cmd_we = 1'b1; cmd_addr = 8'hAA;
        repeat (3) @(negedge clk);
        checks++;
        if (observed() !== 15'd0) begin
            fails++;
            $display("FAIL R1 actual=%h expected=%h", observed(), 15'd0);
        end
        sleep_req = 1'b0; cmd_sel = 1'b0; cmd_we = 1'b0; cmd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: normal forwarding: read, write, deselect
        step(0, 1, 0, 8'h11, 0, 0, "R10");
        step(0, 1, 1, 8'h22, 0, 0, "R10");
        step(0, 0, 0, 8'h33, 0, 0, "R8");

        // R3: one-edge request pulse is cancelled
        step(1, 0, 0, 8'h00, 0, 0, "R3");
        step(0, 0, 0, 8'h00, 0, 0, "R3");
        step(0, 1, 0, 8'h3B, 0, 0, "R3");
        step(0, 1, 1, 8'h3C, 0, 0, "R10");
        step(0, 0, 0, 8'h00, 0, 0, "R3");
        step(0, 0, 0, 8'h00, 0, 0, "R3");

        // R2: entry on the fourth edge; commands during entry still pass
        step(1, 0, 0, 8'h00, 0, 0, "R2");
        step(1, 0, 0, 8'h00, 0, 0, "R2");
        step(1, 1, 0, 8'h44, 0, 0, "R10");
        step(1, 1, 1, 8'h55, 1, 0, "R2");

        // R4 / R5 / R8: asleep, commands ignored, address retained
        step(1, 1, 1, 8'h90, 1, 0, "R4");
        step(1, 1, 0, 8'h91, 1, 0, "R4");
        step(1, 0, 0, 8'h92, 1, 0, "R5");
        step(1, 1, 1, 8'h93, 1, 0, "R8");
        step(1, 1, 0, 8'h94, 1, 0, "R5");
        step(1, 0, 1, 8'h95, 1, 0, "R5");

        // R6: wake on third edge, then eight recovery cycles (R7 filtering)
        step(0, 1, 1, 8'h60, 1, 0, "R6");
        step(0, 1, 0, 8'h61, 1, 0, "R6");
        step(0, 1, 1, 8'h62, 0, 1, "R6");
        step(0, 1, 1, 8'h63, 0, 1, "R7");
        step(0, 1, 0, 8'h64, 0, 1, "R7");
        step(0, 1, 1, 8'h65, 0, 1, "R7");
        step(0, 0, 0, 8'h66, 0, 1, "R7");
        step(0, 1, 0, 8'h67, 0, 1, "R9");
        step(0, 0, 1, 8'h68, 0, 1, "R8");
        step(0, 1, 1, 8'h69, 0, 1, "R7");
        step(0, 1, 1, 8'h6A, 0, 0, "R6");

        // R10: normal operation after recovery
        step(0, 1, 1, 8'h70, 0, 0, "R10");
        step(0, 1, 0, 8'h71, 0, 0, "R10");
        step(0, 0, 0, 8'h72, 0, 0, "R8");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule